// File: doc/BRIEF.md
# Holdover Frequency Averager

This block holds the frequency word that a digital PLL falls back on when it loses its reference. Each time the loop presents a new instantaneous frequency word with a valid strobe, a first-order recursive filter moves its running average toward that word. Beside the filter sits a register that host software can write with a frequency word of its own. Two configuration bytes choose where the holdover frequency comes from. It can be the live average, the written word, or a copy of the average frozen when holdover begins. The bytes also select a fast or slow filter time constant.

A simple strobe interface is used for host access. One configuration bit makes reads of the frequency register return the live filtered average instead of the written word. Software can then use the fast filter as an anti-aliasing stage, filter further on its own (for example against temperature), and write a corrected word back. That word takes effect at once, even while holdover is running.

Top module: `hofreq_avg`

## Requirements
- R1: With bit 5 of the holdover-mode byte set, a read of address 0 returns the filter average as it stood in the read cycle, even if address 0 is written in that same cycle. With bit 5 clear, the read returns the written word as it stood before any same-cycle write. Read data appears on `hst_rdata` the cycle after `hst_rd` and holds until the next read.
- R2: The average changes only in cycles where `smp_vld` is high, in every mode. With the strobe low it holds regardless of `smp_word`.
- R3: On each valid sample the average becomes avg + ((smp_word − avg) >>> k). k is 4 when bits 7 and 6 of the holdover-mode byte are both set, and 10 otherwise.
- R4: With manual holdover off and bit 6 (automatic averaging) of the holdover-mode byte set, `ho_word` equals the live average, including the update made at the latest edge.
- R5: With bit 4 of the input-mode byte (manual holdover) set, `ho_word` equals the word written at address 0. A new write shows on `ho_word` the cycle after the write, whether or not `holdover_on` is high.
- R6: With manual holdover and automatic averaging both off, `ho_word` equals the average captured at the last rising edge of `holdover_on`, taken before that cycle's sample update. It stays fixed while later samples arrive, and it is 0 before any rising edge.
- R7: While `rst_n` is low and for two clock edges after it rises, the average, the written word, both mode bytes, the frozen copy and `hst_rdata` are all 0.
- R8: Frequency words are 32-bit two's complement, and the shift rounds toward minus infinity. For example, from an average of 0 with k = 4, a sample of −1600 gives −100.
- R9: Address 1 writes and reads the holdover-mode byte and address 2 the input-mode byte, both in bits 7:0 with zeros above. A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Frequency sample valid strobe |
| smp_word | input | 32 | Instantaneous loop frequency word, two's complement |
| holdover_on | input | 1 | Loop is in holdover |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_addr | input | 2 | Host register address (0 frequency, 1 holdover mode, 2 input mode) |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, registered |
| ho_word | output | 32 | Frequency word holdover will use |

## Verification
A sample, a write or a rising `holdover_on` changes one register at the next clock edge. The effect on `ho_word` is therefore visible one edge after the stimulus. Read data is also registered, so it lands one edge after the read strobe, and reset release costs two further edges of synchronisation. The behavioural model in the bench advances at each rising edge with these same latencies. Both outputs are compared against it at the falling edge that follows, where no register is changing. Directed checks sample at that same falling edge, just after the edge that consumed the stimulus.

// File: rtl/hofreq_pkg.sv
package hofreq_pkg;
  localparam int unsigned FW_DEFAULT = 32;

  typedef enum logic [1:0] {
    ADR_FREQ  = 2'd0,
    ADR_HMODE = 2'd1,
    ADR_IMODE = 2'd2,
    ADR_NONE  = 2'd3
  } hadr_e;

  // bit positions inside the configuration bytes
  localparam int unsigned HM_FAST_B  = 7;
  localparam int unsigned HM_AUTO_B  = 6;
  localparam int unsigned HM_RDAVG_B = 5;
  localparam int unsigned IM_MAN_B   = 4;

  typedef struct packed {
    logic fast;
    logic autoavg;
    logic rdavg;
    logic manual;
  } hcfg_t;
endpackage

// File: rtl/hofreq_iir.sv
module hofreq_iir #(
  parameter int unsigned FW     = 32,
  parameter int unsigned K_FAST = 4,
  parameter int unsigned K_SLOW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [FW-1:0] smp_word,
  input  logic          fast_sel,
  output logic [FW-1:0] avg_q
);
  localparam int unsigned DW = FW + 1;

  logic signed [DW-1:0] diff;
  logic        [FW-1:0] step_fast;
  logic        [FW-1:0] step_slow;
  logic        [FW-1:0] step;
  logic        [FW-1:0] avg_d;

  always_comb begin
    diff      = $signed({smp_word[FW-1], smp_word}) - $signed({avg_q[FW-1], avg_q});
    step_fast = FW'(diff >>> K_FAST);
    step_slow = FW'(diff >>> K_SLOW);
    step      = fast_sel ? step_fast : step_slow;
    avg_d     = avg_q;
    if (smp_vld) begin
      avg_d = avg_q + step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avg_q <= '0;
    end else begin
      avg_q <= avg_d;
    end
  end
endmodule

// File: rtl/hofreq_regs.sv
module hofreq_regs
  import hofreq_pkg::*;
#(
  parameter int unsigned FW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic [1:0]    addr,
  input  logic [FW-1:0] wdata,
  input  logic [FW-1:0] avg_word,
  output logic [FW-1:0] rdata,
  output logic [FW-1:0] hold_word,
  output hcfg_t         cfg
);
  logic [7:0]    hmode_q, hmode_d;
  logic [7:0]    imode_q, imode_d;
  logic [FW-1:0] hold_d;
  logic [FW-1:0] rdata_d;
  hadr_e         adr;

  assign adr = hadr_e'(addr);

  always_comb begin
    hold_d  = hold_word;
    hmode_d = hmode_q;
    imode_d = imode_q;
    if (wr) begin
      unique case (adr)
        ADR_FREQ:  hold_d  = wdata;
        ADR_HMODE: hmode_d = wdata[7:0];
        ADR_IMODE: imode_d = wdata[7:0];
        default:   ;
      endcase
    end
  end

  always_comb begin
    rdata_d = rdata;
    if (rd) begin
      unique case (adr)
        ADR_FREQ:  rdata_d = cfg.rdavg ? avg_word : hold_word;
        ADR_HMODE: rdata_d = FW'(hmode_q);
        ADR_IMODE: rdata_d = FW'(imode_q);
        default:   rdata_d = '0;
      endcase
    end
  end

  always_comb begin
    cfg.fast    = hmode_q[HM_FAST_B] & hmode_q[HM_AUTO_B];
    cfg.autoavg = hmode_q[HM_AUTO_B];
    cfg.rdavg   = hmode_q[HM_RDAVG_B];
    cfg.manual  = imode_q[IM_MAN_B];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_word <= '0;
      hmode_q   <= '0;
      imode_q   <= '0;
      rdata     <= '0;
    end else begin
      hold_word <= hold_d;
      hmode_q   <= hmode_d;
      imode_q   <= imode_d;
      rdata     <= rdata_d;
    end
  end
endmodule

// File: rtl/hofreq_sel.sv
module hofreq_sel #(
  parameter int unsigned FW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          holdover_on,
  input  logic [FW-1:0] avg_word,
  input  logic [FW-1:0] hold_word,
  input  logic          cfg_auto,
  input  logic          cfg_manual,
  output logic [FW-1:0] ho_word
);
  logic          ho_prev_q;
  logic [FW-1:0] snap_q, snap_d;
  logic          entry;

  always_comb begin
    entry  = holdover_on & ~ho_prev_q;
    snap_d = snap_q;
    if (entry) begin
      snap_d = avg_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ho_prev_q <= 1'b0;
      snap_q    <= '0;
    end else begin
      ho_prev_q <= holdover_on;
      snap_q    <= snap_d;
    end
  end

  always_comb begin
    if (cfg_manual) begin
      ho_word = hold_word;
    end else if (cfg_auto) begin
      ho_word = avg_word;
    end else begin
      ho_word = snap_q;
    end
  end
endmodule

// File: rtl/hofreq_avg.sv
module hofreq_avg
  import hofreq_pkg::*;
#(
  parameter int unsigned FW          = FW_DEFAULT,
  parameter int unsigned K_FAST      = 4,
  parameter int unsigned K_SLOW      = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [FW-1:0] smp_word,
  input  logic          holdover_on,
  input  logic          hst_wr,
  input  logic          hst_rd,
  input  logic [1:0]    hst_addr,
  input  logic [FW-1:0] hst_wdata,
  output logic [FW-1:0] hst_rdata,
  output logic [FW-1:0] ho_word
);
  logic [SYNC_STAGES-1:0] rsync_q;
  logic                   rst_sync_n;
  logic [FW-1:0]          avg_word;
  logic [FW-1:0]          hold_word;
  hcfg_t                  cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rsync_q[SYNC_STAGES-1];

  hofreq_iir #(.FW(FW), .K_FAST(K_FAST), .K_SLOW(K_SLOW)) iir_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .smp_vld  (smp_vld),
    .smp_word (smp_word),
    .fast_sel (cfg.fast),
    .avg_q    (avg_word)
  );

  hofreq_regs #(.FW(FW)) regs_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr        (hst_wr),
    .rd        (hst_rd),
    .addr      (hst_addr),
    .wdata     (hst_wdata),
    .avg_word  (avg_word),
    .rdata     (hst_rdata),
    .hold_word (hold_word),
    .cfg       (cfg)
  );

  hofreq_sel #(.FW(FW)) sel_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .holdover_on (holdover_on),
    .avg_word    (avg_word),
    .hold_word   (hold_word),
    .cfg_auto    (cfg.autoavg),
    .cfg_manual  (cfg.manual),
    .ho_word     (ho_word)
  );
endmodule

// File: rtl/hofreq_avg_chk.sv
module hofreq_avg_chk #(
  parameter int unsigned FW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_vld,
  input logic          holdover_on,
  input logic          hst_rd,
  input logic [1:0]    hst_addr,
  input logic          cfg_rdavg,
  input logic          cfg_auto,
  input logic          cfg_manual,
  input logic [FW-1:0] avg_word,
  input logic [FW-1:0] hold_word,
  input logic [FW-1:0] ho_word,
  input logic [FW-1:0] hst_rdata
);
  AST_AVG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(avg_word)); // R2

  AST_MANUAL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_manual |-> ho_word == hold_word); // R5

  AST_AUTO_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_manual && cfg_auto) |-> ho_word == avg_word); // R4

  AST_FREEZE_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(holdover_on) && !cfg_manual && !cfg_auto)
      |=> (cfg_manual || cfg_auto || ho_word == $past(avg_word))); // R6

  AST_READ_AVERAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_rd && hst_addr == 2'd0 && cfg_rdavg) |=> hst_rdata == $past(avg_word)); // R1
endmodule

bind hofreq_avg hofreq_avg_chk #(.FW(FW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .smp_vld     (smp_vld),
  .holdover_on (holdover_on),
  .hst_rd      (hst_rd),
  .hst_addr    (hst_addr),
  .cfg_rdavg   (cfg.rdavg),
  .cfg_auto    (cfg.autoavg),
  .cfg_manual  (cfg.manual),
  .avg_word    (avg_word),
  .hold_word   (hold_word),
  .ho_word     (ho_word),
  .hst_rdata   (hst_rdata)
);

// File: tb/hofreq_avg_tb_top.sv
module hofreq_avg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_vld = 1'b0;
  logic [31:0] smp_word = '0;
  logic        holdover_on = 1'b0;
  logic        hst_wr = 1'b0;
  logic        hst_rd = 1'b0;
  logic [1:0]  hst_addr = '0;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic [31:0] ho_word;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk; // 250 MHz

  hofreq_avg dut_i (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_word(smp_word),
    .holdover_on(holdover_on), .hst_wr(hst_wr), .hst_rd(hst_rd),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .ho_word(ho_word)
  );

  // behavioural reference model
  bit          s1, s2;
  int          m_acc, m_wr, m_snap;
  bit   [7:0]  m_hm, m_im;
  bit   [31:0] m_rd;
  bit          m_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 = 0; s2 = 0; m_acc = 0; m_wr = 0; m_snap = 0;
      m_hm = 0; m_im = 0; m_rd = 0; m_prev = 0;
    end else if (!s2) begin
      s2 = s1; s1 = 1;
    end else begin
      int     old;
      longint d;
      int     k;
      old = m_acc;
      if (hst_rd) begin
        case (hst_addr)
          2'd0: m_rd = m_hm[5] ? old : m_wr;
          2'd1: m_rd = {24'd0, m_hm};
          2'd2: m_rd = {24'd0, m_im};
          default: m_rd = 0;
        endcase
      end
      if (smp_vld) begin
        k = (m_hm[7] && m_hm[6]) ? 4 : 10;
        d = longint'($signed(smp_word)) - longint'(old);
        m_acc = int'(longint'(old) + (d >>> k));
      end
      if (holdover_on && !m_prev) m_snap = old;
      m_prev = holdover_on;
      if (hst_wr) begin
        case (hst_addr)
          2'd0: m_wr = hst_wdata;
          2'd1: m_hm = hst_wdata[7:0];
          2'd2: m_im = hst_wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    int exp_ho;
    exp_ho = m_im[4] ? m_wr : (m_hm[6] ? m_acc : m_snap);
    chk(m_im[4] ? "R5 model ho_word" : (m_hm[6] ? "R4 model ho_word" : "R6 model ho_word"),
        ho_word, exp_ho);
    chk("R1/R9 model rdata", hst_rdata, m_rd);
  end

  task automatic tick();
    @(negedge clk);
    smp_vld = 0; hst_wr = 0; hst_rd = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] v);
    hst_wr = 1; hst_addr = a; hst_wdata = v; tick();
  endtask

  task automatic rd(input logic [1:0] a);
    hst_rd = 1; hst_addr = a; tick();
  endtask

  task automatic smp(input int v);
    smp_vld = 1; smp_word = v; tick();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: outputs zero during reset
    chk("R7 ho_word in reset", ho_word, 32'd0);
    chk("R7 rdata in reset", hst_rdata, 32'd0);
    rst_n = 1;
    repeat (3) tick();
    chk("R7 ho_word after release", ho_word, 32'd0);

    // R3/R4/R8: fast automatic, negative sample
    wr(2'd1, 32'hC0);
    smp(-1600);
    chk("R8 fast step on negative sample", ho_word, 32'hFFFF_FF9C);
    // R2: strobe low, word changing
    smp_word = 32'd50000; tick();
    smp_word = 32'd7; tick();
    chk("R2 no update without strobe", ho_word, 32'hFFFF_FF9C);
    // R3: slow automatic
    wr(2'd1, 32'h40);
    smp(-100 + 3072);
    chk("R3 slow step", ho_word, 32'(-97));
    // R6: neither auto nor manual, bit 7 alone -> slow, frozen copy 0
    wr(2'd1, 32'h80);
    smp(-97 + 2048);
    chk("R6 zero before any entry", ho_word, 32'd0);
    holdover_on = 1; tick();
    chk("R6 captured on entry", ho_word, 32'(-95));
    smp(1 << 20);
    smp(1 << 20);
    chk("R6 held after later samples", ho_word, 32'(-95));
    // R1: read_average with same-cycle write
    wr(2'd1, 32'h20);
    hst_wr = 1; hst_rd = 1; hst_addr = 2'd0; hst_wdata = 32'h1234_5678; tick();
    chk("R1 read returns average despite write", hst_rdata, 32'(m_acc));
    wr(2'd1, 32'h00);
    rd(2'd0);
    chk("R1 read returns written word", hst_rdata, 32'h1234_5678);
    // R9: mode byte readback
    wr(2'd1, 32'hFFFF_FFE0);
    rd(2'd1);
    chk("R9 holdover-mode readback", hst_rdata, 32'h0000_00E0);
    rd(2'd3);
    chk("R9 unused address reads zero", hst_rdata, 32'd0);
    // R5: manual holdover, update during holdover
    wr(2'd2, 32'h10);
    chk("R5 manual selects written word", ho_word, 32'h1234_5678);
    rd(2'd2);
    chk("R9 input-mode readback", hst_rdata, 32'h0000_0010);
    wr(2'd0, 32'h0BAD_F00D);
    chk("R5 rewrite during holdover", ho_word, 32'h0BAD_F00D);

    // random traffic, model compared every cycle
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 15);
      holdover_on = ($urandom_range(0, 7) != 0) ? holdover_on : ~holdover_on;
      smp_vld = r[0]; smp_word = $urandom;
      if (r[3:1] == 3'd0) begin
        hst_wr = 1; hst_addr = 2'($urandom_range(0, 3));
        hst_wdata = (hst_addr == 2'd0) ? $urandom : {24'd0, 8'($urandom) & 8'hF0};
      end
      hst_rd = r[2]; if (!hst_wr) hst_addr = 2'($urandom_range(0, 3));
      tick();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule